// File: doc/BRIEF.md
# Code and Mask Acceptance Filter

This block sits between the frame decoder of a serial bus controller and its receive store. It decides, for every decoded frame, whether the frame is kept. A 32-bit code word gives the bit pattern a frame must carry. A 32-bit mask word marks some of those bits as don't-care. A frame passes only if every bit that the filter examines either equals its code bit or is masked.

The same 64 bits of code and mask can be read as one wide filter or as two narrow filters, and the mode input chooses which. Which code bits line up with which frame field also depends on the frame format: the identifier is 11 bits for standard frames and 29 bits for extended frames. The decoder presents the frame fields with a one-cycle valid strobe. One clock later the block raises either a store pulse or a drop pulse for one cycle. The code and mask words change only while the controller is held in reset mode.

Top module: `acf_filter`

## Requirements
- R1: After reset the code word is all zeros, the mask word is all ones (every frame passes), and both store and drop are low.
- R2: While reset_mode is high, a cfg_wr_en cycle loads cfg_wr_data into the code word when cfg_wr_sel is 0, or into the mask word when cfg_wr_sel is 1. The new value applies to frames presented from the next cycle on.
- R3: While reset_mode is low, cfg_wr_en has no effect on either word.
- R4: A mask bit of 1 makes the matching code bit don't-care. A mask bit of 0 requires the frame bit to equal the code bit. An all-ones mask passes every frame.
- R5: A frame_valid cycle produces, in the next cycle, exactly one of store or drop, each lasting one cycle. Both stay low after a cycle without frame_valid.
- R6: Single filter, standard frame (frm_ext=0, dual_mode=0): code[31:21] is compared with frm_id[10:0] and code[20] with frm_rtr. frm_id[28:11] is ignored.
- R7: Single filter, standard frame: code[15:8] is compared with data byte 0 only when frm_rtr=0 and frm_dlc>=1. code[7:0] is compared with data byte 1 only when frm_rtr=0 and frm_dlc>=2.
- R8: Single filter, extended frame: code[31:3] is compared with frm_id[28:0] and code[2] with frm_rtr. Data bytes are ignored.
- R9: Dual filter, standard frame. Filter A compares code[31:21] with the identifier, code[20] with the remote flag, code[19:16] with data byte 0 bits 7:4 and code[3:0] with data byte 0 bits 3:0. Filter B compares code[15:5] with the identifier and code[4] with the remote flag. The frame passes if either filter matches.
- R10: Dual filter, standard frame: filter A skips the data byte 0 nibbles when frm_rtr=1 or frm_dlc=0.
- R11: Dual filter, extended frame: frm_id[28:13] is compared with code[31:16] (filter A) and with code[15:0] (filter B). The frame passes if either matches.
- R12: Code bits that the active mapping does not use have no effect: bits 19:16 in single standard mode and bits 1:0 in single extended mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_mode | input | 1 | Controller held in reset mode; opens the configuration words for writing |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | 0 selects the code word, 1 selects the mask word |
| cfg_wr_data | input | 32 | Configuration write data |
| dual_mode | input | 1 | 0 = one wide filter, 1 = two narrow filters |
| frm_valid | input | 1 | Decoded frame fields are valid in this cycle |
| frm_ext | input | 1 | 1 = extended (29-bit identifier) frame |
| frm_id | input | 29 | Identifier; standard frames use bits 10:0 |
| frm_rtr | input | 1 | Remote-request flag |
| frm_dlc | input | 4 | Data length code |
| frm_data0 | input | 8 | First data byte |
| frm_data1 | input | 8 | Second data byte |
| store | output | 1 | One-cycle pulse: frame accepted, store request |
| drop | output | 1 | One-cycle pulse: frame rejected |

## Verification
The assertions check on every cycle that the configuration words stay frozen outside reset mode, and that a write in reset mode lands in the selected word. They also check that each strobe yields exactly one outcome pulse one cycle later, that no pulse appears without a strobe, and that an all-ones mask always yields store. Only the bench scenarios can show the field mappings. These cover the bit positions for each mode and format, the skipping of data bytes for remote and short frames, the OR of the two dual filters, and the indifference to unused code bits. The bench shows them by comparing each outcome with an independent model over random and directed frames.

// File: rtl/acf_pkg.sv
package acf_pkg;
   localparam int unsigned ACF_EXT_ID_W = 29;
   localparam int unsigned ACF_DLC_W    = 4;
   localparam int unsigned ACF_BYTE_W   = 8;

   typedef enum logic {
      SEL_CODE = 1'b0,
      SEL_MASK = 1'b1
   } acf_sel_e;

   typedef struct packed {
      logic                    ext;
      logic                    rtr;
      logic [ACF_DLC_W-1:0]    dlc;
      logic [ACF_EXT_ID_W-1:0] id;
      logic [ACF_BYTE_W-1:0]   d0;
      logic [ACF_BYTE_W-1:0]   d1;
   } acf_frame_t;
endpackage

// File: rtl/acf_cfg_regs.sv
module acf_cfg_regs
   import acf_pkg::*;
#(
   parameter int unsigned    REG_W    = 32,
   parameter logic [REG_W-1:0] MASK_RST = '1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reset_mode,
   input  logic             wr_en,
   input  acf_sel_e         wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] code_q,
   output logic [REG_W-1:0] mask_q
);
   logic wr_ok;
   assign wr_ok = reset_mode & wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         mask_q <= MASK_RST;
      end else if (wr_ok) begin
         if (wr_sel == SEL_CODE) code_q <= wr_data;
         else                    mask_q <= wr_data;
      end
   end

   // R3: words frozen while the controller is operating
   p_frozen_outside_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !reset_mode |=> ($stable(code_q) && $stable(mask_q)));

   // R2: a write in reset mode lands in the selected word
   p_code_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_mode && wr_en && wr_sel == SEL_CODE) |=> (code_q == $past(wr_data)));

   p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_mode && wr_en && wr_sel == SEL_MASK) |=> (mask_q == $past(wr_data)));
endmodule

// File: rtl/acf_vec_build.sv
module acf_vec_build
   import acf_pkg::*;
#(
   parameter int unsigned REG_W    = 32,
   parameter int unsigned STD_ID_W = 11,
   parameter int unsigned NF       = 2
)(
   input  acf_frame_t                   frm,
   input  logic                         dual,
   output logic [NF-1:0][REG_W-1:0]     fv,
   output logic [NF-1:0][REG_W-1:0]     care,
   output logic [NF-1:0]                en
);
   localparam int unsigned HALF    = REG_W / 2;
   localparam int unsigned SID_LO  = REG_W - STD_ID_W;
   localparam int unsigned SRTR    = SID_LO - 1;
   localparam int unsigned XID_LO  = REG_W - ACF_EXT_ID_W;
   localparam int unsigned XRTR    = XID_LO - 1;
   localparam int unsigned B0_LO   = 2 * ACF_BYTE_W - ACF_BYTE_W;
   localparam int unsigned NIB     = ACF_BYTE_W / 2;
   localparam int unsigned NH_LO   = SRTR - NIB;
   localparam int unsigned BID_LO  = HALF - STD_ID_W;
   localparam int unsigned BRTR    = BID_LO - 1;

   logic data1_ok, data2_ok;
   assign data1_ok = !frm.rtr && (frm.dlc >= ACF_DLC_W'(1));
   assign data2_ok = !frm.rtr && (frm.dlc >= ACF_DLC_W'(2));

   always_comb begin
      fv   = '0;
      care = '0;
      en   = '0;
      en[0] = 1'b1;
      if (!dual) begin
         if (!frm.ext) begin
            fv[0][REG_W-1:SID_LO]   = frm.id[STD_ID_W-1:0];
            care[0][REG_W-1:SID_LO] = '1;
            fv[0][SRTR]             = frm.rtr;
            care[0][SRTR]           = 1'b1;
            fv[0][B0_LO +: ACF_BYTE_W] = frm.d0;
            fv[0][0 +: ACF_BYTE_W]     = frm.d1;
            if (data1_ok) care[0][B0_LO +: ACF_BYTE_W] = '1;
            if (data2_ok) care[0][0 +: ACF_BYTE_W]     = '1;
         end else begin
            fv[0][REG_W-1:XID_LO]   = frm.id;
            care[0][REG_W-1:XID_LO] = '1;
            fv[0][XRTR]             = frm.rtr;
            care[0][XRTR]           = 1'b1;
         end
      end else begin
         en = '1;
         if (!frm.ext) begin
            fv[0][REG_W-1:SID_LO]   = frm.id[STD_ID_W-1:0];
            care[0][REG_W-1:SID_LO] = '1;
            fv[0][SRTR]             = frm.rtr;
            care[0][SRTR]           = 1'b1;
            fv[0][NH_LO +: NIB]     = frm.d0[ACF_BYTE_W-1:NIB];
            fv[0][0 +: NIB]         = frm.d0[NIB-1:0];
            if (data1_ok) begin
               care[0][NH_LO +: NIB] = '1;
               care[0][0 +: NIB]     = '1;
            end
            fv[1][HALF-1:BID_LO]    = frm.id[STD_ID_W-1:0];
            care[1][HALF-1:BID_LO]  = '1;
            fv[1][BRTR]             = frm.rtr;
            care[1][BRTR]           = 1'b1;
         end else begin
            fv[0][REG_W-1:HALF]     = frm.id[ACF_EXT_ID_W-1 -: HALF];
            care[0][REG_W-1:HALF]   = '1;
            fv[1][HALF-1:0]         = frm.id[ACF_EXT_ID_W-1 -: HALF];
            care[1][HALF-1:0]       = '1;
         end
      end
   end
endmodule

// File: rtl/acf_cmp.sv
module acf_cmp #(
   parameter int unsigned REG_W = 32
)(
   input  logic             en,
   input  logic [REG_W-1:0] fv,
   input  logic [REG_W-1:0] care,
   input  logic [REG_W-1:0] code,
   input  logic [REG_W-1:0] mask,
   output logic             hit
);
   logic [REG_W-1:0] diff;
   assign diff = (fv ^ code) & ~mask & care;
   assign hit  = en && (diff == '0);

   // R4: an all-ones mask can never cause a miss on an enabled filter
   always_comb begin
      if (en && (&mask)) begin
         p_dontcare_hit_r4: assert (hit);
      end
   end
endmodule

// File: rtl/acf_filter.sv
module acf_filter
   import acf_pkg::*;
#(
   parameter int unsigned REG_W    = 32,
   parameter int unsigned STD_ID_W = 11,
   parameter int unsigned NF       = 2
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reset_mode,
   input  logic                    cfg_wr_en,
   input  logic                    cfg_wr_sel,
   input  logic [REG_W-1:0]        cfg_wr_data,
   input  logic                    dual_mode,
   input  logic                    frm_valid,
   input  logic                    frm_ext,
   input  logic [ACF_EXT_ID_W-1:0] frm_id,
   input  logic                    frm_rtr,
   input  logic [ACF_DLC_W-1:0]    frm_dlc,
   input  logic [ACF_BYTE_W-1:0]   frm_data0,
   input  logic [ACF_BYTE_W-1:0]   frm_data1,
   output logic                    store,
   output logic                    drop
);
   initial begin
      a_reg_w: assert (REG_W == 32) else $error("REG_W must be 32");
      a_std_w: assert (STD_ID_W + 1 + 2 * ACF_BYTE_W <= REG_W) else $error("STD_ID_W too wide");
      a_nf:    assert (NF == 2) else $error("NF must be 2");
   end

   logic [REG_W-1:0]          code_q, mask_q;
   acf_frame_t                frm;
   logic [NF-1:0][REG_W-1:0]  fv, care;
   logic [NF-1:0]             en, hit;
   logic                      accept;
   logic                      store_q, drop_q;

   assign frm = '{ext: frm_ext, rtr: frm_rtr, dlc: frm_dlc, id: frm_id,
                  d0: frm_data0, d1: frm_data1};

   acf_cfg_regs #(.REG_W(REG_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .reset_mode (reset_mode),
      .wr_en      (cfg_wr_en),
      .wr_sel     (acf_sel_e'(cfg_wr_sel)),
      .wr_data    (cfg_wr_data),
      .code_q     (code_q),
      .mask_q     (mask_q)
   );

   acf_vec_build #(.REG_W(REG_W), .STD_ID_W(STD_ID_W), .NF(NF)) u_vec (
      .frm  (frm),
      .dual (dual_mode),
      .fv   (fv),
      .care (care),
      .en   (en)
   );

   for (genvar g = 0; g < NF; g++) begin : g_flt
      acf_cmp #(.REG_W(REG_W)) u_cmp (
         .en   (en[g]),
         .fv   (fv[g]),
         .care (care[g]),
         .code (code_q),
         .mask (mask_q),
         .hit  (hit[g])
      );
   end

   assign accept = |hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= 1'b0;
         drop_q  <= 1'b0;
      end else begin
         store_q <= frm_valid & accept;
         drop_q  <= frm_valid & ~accept;
      end
   end

   assign store = store_q;
   assign drop  = drop_q;

   // R5: one outcome per strobe, one cycle later
   p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> (store ^ drop));

   p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> !(store || drop));

   // R4: all-ones mask passes every frame
   p_accept_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && (&mask_q)) |=> store);
endmodule

// File: tb/acf_filter_tb.sv
module acf_filter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reset_mode = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic        cfg_wr_sel = 1'b0;
   logic [31:0] cfg_wr_data = '0;
   logic        dual_mode = 1'b0;
   logic        frm_valid = 1'b0;
   logic        frm_ext = 1'b0;
   logic [28:0] frm_id = '0;
   logic        frm_rtr = 1'b0;
   logic [3:0]  frm_dlc = '0;
   logic [7:0]  frm_data0 = '0;
   logic [7:0]  frm_data1 = '0;
   logic        store, drop;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   logic [31:0] sh_code = '0;
   logic [31:0] sh_mask = '1;

   always #5 clk = ~clk;

   acf_filter u_dut (
      .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
      .dual_mode(dual_mode), .frm_valid(frm_valid), .frm_ext(frm_ext),
      .frm_id(frm_id), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
      .frm_data0(frm_data0), .frm_data1(frm_data1),
      .store(store), .drop(drop)
   );

   function automatic bit fm(int w, logic [31:0] c, logic [31:0] m, logic [31:0] v);
      logic [63:0] sel = (64'd1 << w) - 64'd1;
      return ((({32'd0, c} ^ {32'd0, v}) & ~{32'd0, m} & sel) == 64'd0);
   endfunction

   function automatic bit model(logic [31:0] c, logic [31:0] m, bit dual, bit ext,
                                logic [28:0] id, bit rtr, logic [3:0] dlc,
                                logic [7:0] d0, logic [7:0] d1);
      bit fa, fb;
      if (!dual && !ext)
         return fm(11, c >> 21, m >> 21, 32'(id[10:0])) && fm(1, c >> 20, m >> 20, 32'(rtr))
             && (rtr || dlc < 1 || fm(8, c >> 8, m >> 8, 32'(d0)))
             && (rtr || dlc < 2 || fm(8, c, m, 32'(d1)));
      if (!dual && ext)
         return fm(29, c >> 3, m >> 3, 32'(id)) && fm(1, c >> 2, m >> 2, 32'(rtr));
      if (!ext) begin
         fa = fm(11, c >> 21, m >> 21, 32'(id[10:0])) && fm(1, c >> 20, m >> 20, 32'(rtr))
           && (rtr || dlc == 0 || (fm(4, c >> 16, m >> 16, 32'(d0[7:4])) && fm(4, c, m, 32'(d0[3:0]))));
         fb = fm(11, c >> 5, m >> 5, 32'(id[10:0])) && fm(1, c >> 4, m >> 4, 32'(rtr));
         return fa || fb;
      end
      fa = fm(16, c >> 16, m >> 16, 32'(id[28:13]));
      fb = fm(16, c, m, 32'(id[28:13]));
      return fa || fb;
   endfunction

   task automatic check(bit exp, string req);
      n_chk++;
      if (store !== exp || drop !== !exp) begin
         n_bad++;
         $display("FAIL %s: store/drop=%b%b expected %b%b", req, store, drop, exp, !exp);
      end
   endtask

   task automatic cfg_write(bit sel, logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
      if (reset_mode) begin
         if (sel) sh_mask = d; else sh_code = d;
      end
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic configure(logic [31:0] c, logic [31:0] m);
      @(negedge clk); reset_mode = 1'b1;
      cfg_write(1'b0, c);
      cfg_write(1'b1, m);
      @(negedge clk); reset_mode = 1'b0;
   endtask

   task automatic send(bit ext, logic [28:0] id, bit rtr, logic [3:0] dlc,
                       logic [7:0] d0, logic [7:0] d1, string req);
      bit exp;
      @(negedge clk);
      frm_valid = 1'b1; frm_ext = ext; frm_id = id; frm_rtr = rtr;
      frm_dlc = dlc; frm_data0 = d0; frm_data1 = d1;
      exp = model(sh_code, sh_mask, dual_mode, ext, id, rtr, dlc, d0, d1);
      @(negedge clk);
      frm_valid = 1'b0;
      check(exp, req);
   endtask

   task automatic send_exp(bit ext, logic [28:0] id, bit rtr, logic [3:0] dlc,
                           logic [7:0] d0, logic [7:0] d1, bit exp, string req);
      @(negedge clk);
      frm_valid = 1'b1; frm_ext = ext; frm_id = id; frm_rtr = rtr;
      frm_dlc = dlc; frm_data0 = d0; frm_data1 = d1;
      @(negedge clk);
      frm_valid = 1'b0;
      check(exp, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0a1c));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: no pulses after reset
      n_chk++;
      if (store !== 1'b0 || drop !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: store/drop=%b%b expected 00", store, drop);
      end
      // R1: reset mask accepts anything
      send_exp(1'b0, 29'h155, 1'b0, 4'd2, 8'h12, 8'h34, 1'b1, "R1");
      send_exp(1'b1, 29'h1abcdef0, 1'b1, 4'd0, 8'h00, 8'h00, 1'b1, "R1");
      // R5: quiet cycle after outcome
      @(negedge clk);
      n_chk++;
      if (store !== 1'b0 || drop !== 1'b0) begin
         n_bad++;
         $display("FAIL R5: idle store/drop=%b%b expected 00", store, drop);
      end

      // R3: writes outside reset mode ignored
      cfg_write(1'b1, 32'h0);
      cfg_write(1'b0, 32'hffff_ffff);
      send_exp(1'b0, 29'h0, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1, "R3");

      // R2 / R6: exact standard id
      configure({11'h2a5, 1'b0, 20'h0}, 32'h000f_ffff);
      send_exp(1'b0, {18'h3ffff, 11'h2a5}, 1'b0, 4'd8, 8'h99, 8'h77, 1'b1, "R6");
      send_exp(1'b0, 29'h2a4, 1'b0, 4'd0, 8'h00, 8'h00, 1'b0, "R2");
      send_exp(1'b0, 29'h2a5, 1'b1, 4'd0, 8'h00, 8'h00, 1'b0, "R6");
      // R4: masking one id bit makes it don't-care
      configure({11'h2a5, 1'b0, 20'h0}, 32'h002f_ffff);
      send_exp(1'b0, 29'h2a4, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1, "R4");

      // R7: data compare gated by remote flag and length
      configure({11'h100, 1'b0, 4'h0, 8'hab, 8'hcd}, 32'h000f_0000);
      send_exp(1'b0, 29'h100, 1'b0, 4'd2, 8'hab, 8'hcd, 1'b1, "R7");
      send_exp(1'b0, 29'h100, 1'b0, 4'd1, 8'hab, 8'h00, 1'b1, "R7");
      send_exp(1'b0, 29'h100, 1'b0, 4'd2, 8'hab, 8'h00, 1'b0, "R7");
      send_exp(1'b0, 29'h100, 1'b0, 4'd0, 8'h11, 8'h22, 1'b1, "R7");
      configure({11'h100, 1'b1, 4'h0, 8'hab, 8'hcd}, 32'h000f_0000);
      send_exp(1'b0, 29'h100, 1'b1, 4'd8, 8'h11, 8'h22, 1'b1, "R7");
      // R12: unused bits 19:16 in single standard mode
      configure({11'h100, 1'b0, 4'hf, 8'h00, 8'h00}, 32'h0000_ffff);
      send_exp(1'b0, 29'h100, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1, "R12");

      // R8 / R12: single extended
      configure({29'h0123_4567, 1'b0, 2'b11}, 32'h0);
      send_exp(1'b1, 29'h0123_4567, 1'b0, 4'd8, 8'hff, 8'hff, 1'b1, "R8");
      send_exp(1'b1, 29'h0123_4566, 1'b0, 4'd0, 8'h00, 8'h00, 1'b0, "R8");
      send_exp(1'b1, 29'h0123_4567, 1'b1, 4'd0, 8'h00, 8'h00, 1'b0, "R12");

      // R9 / R10 / R11: dual mode
      dual_mode = 1'b1;
      configure({11'h055, 1'b0, 4'ha, 11'h7ff, 1'b1, 4'h5}, 32'h0);
      send_exp(1'b0, 29'h055, 1'b0, 4'd1, 8'ha5, 8'h00, 1'b1, "R9");
      send_exp(1'b0, 29'h055, 1'b0, 4'd1, 8'ha6, 8'h00, 1'b0, "R9");
      send_exp(1'b0, 29'h7ff, 1'b1, 4'd0, 8'h00, 8'h00, 1'b1, "R9");
      send_exp(1'b0, 29'h055, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1, "R10");
      configure({11'h055, 1'b1, 4'ha, 11'h7ff, 1'b1, 4'h5}, 32'h0);
      send_exp(1'b0, 29'h055, 1'b1, 4'd4, 8'h00, 8'h00, 1'b1, "R10");
      configure({16'hbeef, 16'h1234}, 32'h0);
      send_exp(1'b1, {16'h1234, 13'h1fff}, 1'b1, 4'd0, 8'h00, 8'h00, 1'b1, "R11");
      send_exp(1'b1, {16'hbeef, 13'h0000}, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1, "R11");
      send_exp(1'b1, {16'hbeee, 13'h0000}, 1'b0, 4'd0, 8'h00, 8'h00, 1'b0, "R11");

      // Random phase
      for (int k = 0; k < 60; k++) begin
         logic [31:0] c, m;
         dual_mode = $urandom_range(0, 1);
         c = $urandom;
         case ($urandom_range(0, 3))
            0: m = $urandom;
            1: m = $urandom & $urandom & $urandom;
            2: m = 32'h0;
            default: m = $urandom & 32'h0000_ffff;
         endcase
         configure(c, m);
         for (int j = 0; j < 12; j++) begin
            bit ext, rtr, near;
            logic [28:0] id;
            logic [7:0] d0, d1;
            logic [3:0] dlc;
            ext = $urandom_range(0, 1);
            rtr = ($urandom_range(0, 3) == 0);
            near = $urandom_range(0, 1);
            dlc = 4'($urandom_range(0, 8));
            id = 29'($urandom);
            d0 = near ? c[15:8] : 8'($urandom);
            d1 = near ? c[7:0]  : 8'($urandom);
            if (near) begin
               if (!ext && !dual_mode) id[10:0] = c[31:21];
               else if (ext && !dual_mode) id = c[31:3];
               else if (!ext) id[10:0] = $urandom_range(0, 1) ? c[31:21] : c[15:5];
               else id[28:13] = $urandom_range(0, 1) ? c[31:16] : c[15:0];
               if (dual_mode && !ext) d0 = {c[19:16], c[3:0]};
               if (!dual_mode && $urandom_range(0, 1)) rtr = ext ? c[2] : c[20];
               if ($urandom_range(0, 7) == 0) id[$urandom_range(0, 28)] ^= 1'b1;
            end
            send(ext, id, rtr, dlc, d0, d1,
                 dual_mode ? (ext ? "R11" : "R9") : (ext ? "R8" : "R6"));
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule